// File: doc/BRIEF.md
# Byte-Wide SPI Port with Receive Buffer and Collision Flag

This block is a serial peripheral interface port that moves one byte at a time, most significant bit first. It runs as a clock master, dividing the system clock to drive the serial clock, or as a slave that follows an external serial clock behind an optional active-low select line. Software never reaches the shift register directly. A write to the data register loads it, and a read of the data register returns the last byte that was captured.

Reception is double-buffered. When a byte completes, the shift register is copied into the receive buffer, a full flag is raised and the interrupt line pulses for one cycle. The next byte may already be shifting while software still has to read the previous one. A byte that completes while the buffer is still full overwrites it and sets an overflow flag. A data write that arrives while a transfer is in flight is discarded and sets a sticky collision flag.

The transfer engine is a three-state machine. IDLE waits. A buffer write while in master mode, or the first leading serial edge while in slave mode, moves it to RUN. RUN processes one serial edge per event. After the last edge it moves to DONE, and a select release in slave mode aborts it back to IDLE. DONE lasts exactly one cycle, during which the buffer is loaded, and then returns to IDLE.

Top module: `spi_port`

## Requirements
- R1: Register map, with addr 0 for control, addr 1 for status and addr 2 for data. The control bits are [0] master, [1] idle clock level, [2] late output phase, [3] sample at end, [5:4] divider code and [6] select enable. The status bits are [0] full, [1] collision, [2] overflow and [3] busy. After reset, both control and status read 0.
- R2: In master mode, a data write while idle starts a transfer. The byte leaves on `sdo` most significant bit first, with exactly 8 serial clock cycles per byte.
- R3: When a byte completes, the received byte appears at addr 2 and status bit 0 reads 1. `irq` is high for exactly one cycle, and that is the first cycle in which the full bit is 1.
- R4: A read of addr 2 clears status bit 0.
- R5: A write to addr 2 while status bit 3 is 1 is dropped, so the byte in flight and the buffer are unaffected, and status bit 1 is set. That bit stays 1 until software writes status with bit 1 set.
- R6: In master mode the serial clock phase lasts 2, 8 or 32 system cycles for divider codes 0, 1 and 2 (a division by 4, 16 or 64). Code 3 behaves like code 2.
- R7: Clock level and phase follow the control bits. The serial clock idles at control bit 1. With bit 2 at 0, data is valid before the leading edge and is sampled on it. With bit 2 at 1, data changes on the leading edge and is sampled on the trailing edge.
- R8: In master mode, control bit 3 delays each input sample by half a serial clock cycle. The transfer therefore lasts exactly one half cycle longer and still captures the correct byte.
- R9: A byte that completes while the full bit is 1 replaces the buffer and sets status bit 2. Writing status with bit 2 set clears it. The next byte may start before the buffer is read.
- R10: In slave mode `sck_oe` is 0, and the byte moves on the externally driven serial clock edges.
- R11: In slave mode with control bit 6 at 1, a high `ss_n` turns `sdo_oe` off and drops any partial byte. No completion is signalled, and the next transfer starts again from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of data clears full) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | One-cycle pulse when a byte completes |
| sck_i | input | 1 | Serial clock input in slave mode |
| sck_o | output | 1 | Serial clock output in master mode |
| sck_oe | output | 1 | High when the port drives the serial clock |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | High when the port drives serial data out |

## Verification
The properties assume that the bus issues at most one strobe per cycle and that in slave mode the serial clock only moves while the port is selected. They also assume that the idle clock level is not reprogrammed during a transfer. The stimulus keeps to these limits: it drives every bus access as a single-cycle strobe at the falling system edge, and it changes control only between transfers. In slave mode it drives the serial lines with phases of ten system cycles, so the two-stage input synchroniser always sees data that is stable around each clock edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef struct packed {
        logic       ss_en;
        logic [1:0] div;
        logic       smp_end;
        logic       cpha;
        logic       cpol;
        logic       master;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int STAT_FULL = 0;
    localparam int STAT_WCOL = 1;
    localparam int STAT_OVF  = 2;
    localparam int STAT_BUSY = 3;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int HALF_FAST = 2,
    parameter int HALF_MID  = 8,
    parameter int HALF_SLOW = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div,
    output logic       tick
);
    localparam int CNT_W = $clog2(HALF_SLOW) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        unique case (div)
            2'd0:    lim = CNT_W'(HALF_FAST - 1);
            2'd1:    lim = CNT_W'(HALF_MID - 1);
            default: lim = CNT_W'(HALF_SLOW - 1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == lim);

endmodule

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ss_n_i,
    input  logic sdi_i,
    output logic sck_lvl,
    output logic sck_edge,
    output logic ss_n_s,
    output logic sdi_s
);
    // bit order per stage: {sdi, ss_n, sck}; select resets to released
    localparam logic [2:0] RST_VEC = 3'b010;

    logic [STAGES-1:0][2:0] stg;
    logic                   sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg      <= {STAGES{RST_VEC}};
            sck_prev <= 1'b0;
        end else begin
            stg      <= {stg[STAGES-2:0], {sdi_i, ss_n_i, sck_i}};
            sck_prev <= stg[STAGES-1][0];
        end
    end

    assign sck_lvl  = stg[STAGES-1][0];
    assign ss_n_s   = stg[STAGES-1][1];
    assign sdi_s    = stg[STAGES-1][2];
    assign sck_edge = sck_lvl ^ sck_prev;

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         master,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         smp_end,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         mtick,
    input  logic         sck_edge,
    input  logic         sck_lvl,
    input  logic         ss_off,
    input  logic         sdi_m,
    input  logic         sdi_s,
    output logic [W-1:0] shreg,
    output logic         busy,
    output logic         done,
    output logic         sck_q,
    output logic         sdo_q
);
    localparam int EDGES = 2 * W;
    localparam int TW    = $clog2(EDGES + 2);
    localparam logic [TW-1:0] LAST_STD = TW'(EDGES);
    localparam logic [TW-1:0] LAST_EXT = TW'(EDGES + 1);

    xfer_state_t   state, state_nx;
    logic [TW-1:0] t, tn, last;
    logic          ev, late, smp, outb, sdi_use;

    // edge event decode
    always_comb begin
        late    = master && smp_end;
        tn      = t + 1'b1;
        last    = late ? LAST_EXT : LAST_STD;
        sdi_use = master ? sdi_m : sdi_s;
        if (master) begin
            ev = (state == ST_RUN) && mtick;
        end else begin
            ev = sck_edge && !ss_off && !load &&
                 ((state == ST_RUN) || (state == ST_IDLE && sck_lvl != cpol));
        end
        if (!late) begin
            smp = cpha ? !tn[0] : tn[0];
        end else begin
            smp = cpha ? (tn[0] && tn >= TW'(3)) : !tn[0];
        end
        outb = cpha ? (tn[0] && tn < TW'(EDGES)) : (!tn[0] && tn < TW'(EDGES));
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (master ? load : ev) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!master && ss_off)      state_nx = ST_IDLE;
                else if (ev && tn == last)  state_nx = ST_DONE;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t     <= '0;
            shreg <= '0;
            sck_q <= 1'b0;
            sdo_q <= 1'b0;
        end else begin
            if (state_nx != ST_RUN) t <= '0;
            else if (ev)            t <= tn;

            if (load) begin
                shreg <= load_data;
                sdo_q <= load_data[W-1];
            end else if (ev) begin
                if (smp)  shreg <= {shreg[W-2:0], sdi_use};
                if (outb) sdo_q <= smp ? shreg[W-2] : shreg[W-1];
            end

            if (master && state == ST_RUN) begin
                if (ev && tn <= TW'(EDGES)) sck_q <= !sck_q;
            end else begin
                sck_q <= cpol;
            end
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

endmodule

// File: rtl/spi_regs.sv
module spi_regs
    import spi_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic         busy,
    input  logic         done,
    input  logic [W-1:0] shreg,
    output ctrl_t        ctrl_q,
    output logic [W-1:0] buf_q,
    output logic         full_q,
    output logic         wcol_q,
    output logic         ovf_q,
    output logic         irq_q,
    output logic         load
);
    logic wr_ctrl, wr_stat, wr_data, rd_data;

    assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
    assign wr_stat = bus_wr && bus_addr == ADDR_STAT;
    assign wr_data = bus_wr && bus_addr == ADDR_DATA;
    assign rd_data = bus_rd && bus_addr == ADDR_DATA;
    assign load    = wr_data && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            buf_q  <= '0;
            full_q <= 1'b0;
            wcol_q <= 1'b0;
            ovf_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= done;
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);

            if (done)         buf_q <= shreg;

            if (done)         full_q <= 1'b1;
            else if (rd_data) full_q <= 1'b0;

            if (done && full_q && !rd_data)      ovf_q <= 1'b1;
            else if (wr_stat && bus_wdata[STAT_OVF]) ovf_q <= 1'b0;

            if (wr_data && busy)                 wcol_q <= 1'b1;
            else if (wr_stat && bus_wdata[STAT_WCOL]) wcol_q <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HALF_FAST   = 2,
    parameter int HALF_MID    = 8,
    parameter int HALF_SLOW   = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq,
    input  logic         sck_i,
    output logic         sck_o,
    output logic         sck_oe,
    input  logic         ss_n,
    input  logic         sdi,
    output logic         sdo,
    output logic         sdo_oe
);
    ctrl_t        ctrl_q;
    logic [W-1:0] buf_q, shreg;
    logic         full_flag, wcol_flag, ovf_flag;
    logic         xfer_busy, xfer_done, load, mtick;
    logic         sck_lvl, sck_edge, ss_n_s, sdi_s, ss_off;

    spi_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(xfer_busy),
        .done(xfer_done), .shreg(shreg), .ctrl_q(ctrl_q), .buf_q(buf_q),
        .full_q(full_flag), .wcol_q(wcol_flag), .ovf_q(ovf_flag),
        .irq_q(irq), .load(load)
    );

    spi_clk_div #(.HALF_FAST(HALF_FAST), .HALF_MID(HALF_MID), .HALF_SLOW(HALF_SLOW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(xfer_busy && ctrl_q.master),
        .div(ctrl_q.div), .tick(mtick)
    );

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ss_n_i(ss_n), .sdi_i(sdi),
        .sck_lvl(sck_lvl), .sck_edge(sck_edge), .ss_n_s(ss_n_s), .sdi_s(sdi_s)
    );

    assign ss_off = ctrl_q.ss_en && ss_n_s;

    spi_shift_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .master(ctrl_q.master), .cpol(ctrl_q.cpol),
        .cpha(ctrl_q.cpha), .smp_end(ctrl_q.smp_end), .load(load),
        .load_data(bus_wdata), .mtick(mtick), .sck_edge(sck_edge),
        .sck_lvl(sck_lvl), .ss_off(ss_off), .sdi_m(sdi), .sdi_s(sdi_s),
        .shreg(shreg), .busy(xfer_busy), .done(xfer_done),
        .sck_q(sck_o), .sdo_q(sdo)
    );

    assign sck_oe = ctrl_q.master;
    assign sdo_oe = ctrl_q.master || !ss_off;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = W'(ctrl_q);
            ADDR_STAT: bus_rdata = W'({xfer_busy, ovf_flag, wcol_flag, full_flag});
            ADDR_DATA: bus_rdata = buf_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
    import spi_port_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic         bus_rd,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic         irq,
    input logic         sck_o,
    input ctrl_t        ctrl_q,
    input logic         busy,
    input logic         done,
    input logic         full,
    input logic         wcol,
    input logic         ovf,
    input logic         ss_off
);
    assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_full_with_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> full);

    assert_read_clears_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_DATA && !done) |=> !full);

    assert_busy_write_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DATA && busy) |=> wcol);

    assert_wcol_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol && !(bus_wr && bus_addr == ADDR_STAT && bus_wdata[STAT_WCOL])) |=> wcol);

    assert_overflow_on_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && !(bus_rd && bus_addr == ADDR_DATA)) |=> ovf);

    assert_sck_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.master && !busy && $past(!busy) && $stable(ctrl_q.cpol)) |-> sck_o == ctrl_q.cpol);

    assert_deselect_aborts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.master && ss_off) |=> !busy);

endmodule

bind spi_port spi_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .sck_o(sck_o),
    .ctrl_q(ctrl_q), .busy(xfer_busy), .done(xfer_done), .full(full_flag),
    .wcol(wcol_flag), .ovf(ovf_flag), .ss_off(ss_off)
);

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq, sck_o, sck_oe, sdo, sdo_oe, sdi;
    logic       sck_drv = 1'b0, ss_n = 1'b1, sdi_drv = 1'b0;
    logic       slave_tb = 1'b0, loop_inv = 1'b0;
    logic       cpol_tb = 1'b0, cpha_tb = 1'b0, mon_en = 1'b0;

    int checks = 0, errors = 0, irq_cnt = 0, hi_cnt = 0, cyc = 0, nbits = 0;
    logic [7:0] cap = 8'd0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    assign sdi = slave_tb ? sdi_drv : (sdo ^ loop_inv);

    spi_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck_i(sck_drv), .sck_o(sck_o), .sck_oe(sck_oe),
        .ss_n(ss_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (irq) irq_cnt++;
        if (mon_en && sck_o != cpol_tb) hi_cnt++;
    end

    // scoreboard monitor: captures sdo on the sampling edge and pops expected bytes
    always @(sck_o) begin
        if (mon_en && ((sck_o != cpol_tb) == !cpha_tb)) begin
            cap = {cap[6:0], sdo};
            nbits++;
            if (nbits == 8) begin
                nbits = 0;
                if (exp_q.size() == 0) chk("R2 unexpected byte", cap, 0);
                else chk("R2 serial msb-first", cap, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq(int base, string req);
        int n = 0;
        while (irq_cnt == base && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(req, irq_cnt, base + 1);
    endtask

    task automatic cfg(bit m, bit cp, bit ph, bit se, logic [1:0] dv, bit ssen);
        bus_write(2'd0, {1'b0, ssen, dv, se, ph, cp, m});
        cpol_tb = cp; cpha_tb = ph; slave_tb = !m;
        repeat (3) @(negedge clk);
    endtask

    task automatic master_xfer(logic [7:0] tx, bit inv, string req, output int dur);
        int base = irq_cnt;
        int t0;
        loop_inv = inv; hi_cnt = 0; nbits = 0;
        exp_q.push_back(tx);
        mon_en = 1'b1;
        bus_write(2'd2, tx);
        t0 = cyc;
        wait_irq(base, req);
        dur = cyc - t0;
        mon_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic slave_xfer(logic [7:0] din, int nb, output logic [7:0] got);
        got = 8'd0;
        for (int i = 7; i > 7 - nb; i--) begin
            sdi_drv = din[i];
            repeat (10) @(negedge clk);
            sck_drv = 1'b1;
            got = {got[6:0], sdo};
            repeat (10) @(negedge clk);
            sck_drv = 1'b0;
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd, got;
        int d0, d1, base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_read(2'd0, rd); chk("R1 ctrl reset", rd, 8'h00);
        bus_read(2'd1, rd); chk("R1 stat reset", rd, 8'h00);
        chk("R1 irq reset", irq, 0);

        // R2 R3 R4 R6 mode 0, div code 0
        cfg(1, 0, 0, 0, 2'd0, 0);
        master_xfer(8'hA5, 0, "R3 irq on completion", d0);
        chk("R6 phase length code0", hi_cnt, 8 * 2);
        bus_read(2'd1, rd); chk("R3 full set", rd[0], 1);
        bus_read(2'd2, rd); chk("R3 buffer data", rd, 8'hA5);
        bus_read(2'd1, rd); chk("R4 read clears full", rd[0], 0);

        // R7 idle high, code 1
        cfg(1, 1, 0, 0, 2'd1, 0);
        chk("R7 idle level high", sck_o, 1);
        master_xfer(8'h3C, 1, "R7 cpol1 done", d0);
        chk("R6 phase length code1", hi_cnt, 8 * 8);
        bus_read(2'd2, rd); chk("R7 cpol1 rx", rd, 8'hC3);

        // R7 late phase, code 2
        cfg(1, 0, 1, 0, 2'd2, 0);
        master_xfer(8'h81, 0, "R7 cpha1 done", d0);
        chk("R6 phase length code2", hi_cnt, 8 * 32);
        bus_read(2'd2, rd); chk("R7 cpha1 rx", rd, 8'h81);

        cfg(1, 1, 1, 0, 2'd0, 0);
        master_xfer(8'h5E, 1, "R7 mode3 done", d0);
        bus_read(2'd2, rd); chk("R7 mode3 rx", rd, 8'hA1);

        // R8 sample at end adds half a serial cycle
        cfg(1, 0, 0, 0, 2'd0, 0);
        master_xfer(8'h6D, 0, "R8 mid done", d0);
        bus_read(2'd2, rd);
        cfg(1, 0, 0, 1, 2'd0, 0);
        master_xfer(8'h6D, 0, "R8 end done", d1);
        chk("R8 extra half period", d1 - d0, 2);
        bus_read(2'd2, rd); chk("R8 end rx", rd, 8'h6D);
        cfg(1, 0, 1, 1, 2'd0, 0);
        master_xfer(8'hB2, 1, "R8 end cpha1 done", d1);
        bus_read(2'd2, rd); chk("R8 end cpha1 rx", rd, 8'h4D);

        // R5 collision
        cfg(1, 0, 0, 0, 2'd1, 0);
        base = irq_cnt; loop_inv = 0; nbits = 0;
        exp_q.push_back(8'h96);
        mon_en = 1'b1;
        bus_write(2'd2, 8'h96);
        repeat (4) @(negedge clk);
        bus_write(2'd2, 8'h11);
        bus_read(2'd1, rd); chk("R5 collision flag", rd[1], 1);
        wait_irq(base, "R5 transfer continues");
        mon_en = 1'b0;
        bus_read(2'd2, rd); chk("R5 dropped write", rd, 8'h96);
        bus_read(2'd1, rd); chk("R5 flag sticky", rd[1], 1);
        bus_write(2'd1, 8'h02);
        bus_read(2'd1, rd); chk("R5 flag cleared", rd[1], 0);

        // R9 overflow
        master_xfer(8'h12, 0, "R9 first", d0);
        master_xfer(8'h34, 0, "R9 second", d0);
        bus_read(2'd1, rd); chk("R9 overflow flag", rd[2:0], 3'b101);
        bus_read(2'd2, rd); chk("R9 overwritten", rd, 8'h34);
        bus_write(2'd1, 8'h04);
        bus_read(2'd1, rd); chk("R9 overflow cleared", rd[2], 0);

        // R10 R11 slave
        cfg(0, 0, 0, 0, 2'd0, 1);
        chk("R10 sck not driven", sck_oe, 0);
        chk("R11 sdo off when released", sdo_oe, 0);
        bus_write(2'd2, 8'hC7);
        ss_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11 sdo on when selected", sdo_oe, 1);
        base = irq_cnt;
        slave_xfer(8'h6B, 8, got);
        chk("R10 slave tx", got, 8'hC7);
        wait_irq(base, "R10 slave done");
        bus_read(2'd2, rd); chk("R10 slave rx", rd, 8'h6B);

        bus_write(2'd2, 8'hF0);
        base = irq_cnt;
        slave_xfer(8'hAA, 4, got);
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11 sdo off after abort", sdo_oe, 0);
        chk("R11 no completion", irq_cnt, base);
        bus_write(2'd2, 8'h0F);
        ss_n = 1'b0;
        repeat (6) @(negedge clk);
        slave_xfer(8'h55, 8, got);
        chk("R11 restart tx", got, 8'h0F);
        wait_irq(base, "R11 restart done");
        bus_read(2'd2, rd); chk("R11 partial dropped", rd, 8'h55);
        chk("R2 scoreboard drained", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule